// File: doc/BRIEF.md
# Hub Downstream Traffic Repeater Gate

This block sits between the per-port line receivers of a five-port hub and its output drivers. Each clock it looks at the decoded bus state (J, K or SE0) of the root port and of four downstream ports. It then decides which direction the hub repeats in. A start of packet on the root port opens a downstream repeat toward every enabled full-speed port. A start of packet on an enabled downstream port hands that port ownership of the root port, and it keeps ownership until its own end of packet.

Ports flagged as low speed hear nothing during ordinary traffic. When the root side reports a decoded preamble token during a downstream repeat, the block admits the low-speed ports and selects their slow drivers on the next clock edge. The clock is the 12 MHz full-speed bit clock, so this is one bit time, inside the four-bit-time limit. Every port stays admitted until the end of packet that closes the low-speed transfer. A frame counter runs on the same clock and restarts whenever a start-of-frame token is reported.

Top module: `hub_repeat_gate`

## Requirements
- R1: While reset is low and after it is released, with no stimulus, dn_drive, dn_ls_drv and up_drive are 0, up_src is 0 and frame_count is 0. Line states are two-bit codes: 2'b00 SE0, 2'b01 J, 2'b10 K, and 2'b11 is treated as neither K nor SE0. Port i uses dn_state bits [2i+1:2i].
- R2: When the block is idle and up_state is K at a clock edge, a downstream repeat starts. From the next cycle on, dn_drive[i] is 1 exactly for ports that are enabled and not low speed. Disabled ports stay at 0.
- R3: Outside the window that a preamble opens, a low-speed port is never driven and its dn_ls_drv bit stays 0.
- R4: An up_pre pulse sampled during a downstream repeat admits low-speed ports from the next cycle until the repeat ends. dn_drive covers every enabled port, and dn_ls_drv[i] is 1 for enabled low-speed ports.
- R5: A repeat ends at the first edge where the source line is not SE0 after it was SE0 at an earlier edge of the same repeat. At that edge all drive outputs fall and the low-speed window closes. An up_pre sampled at that same edge has no effect.
- R6: When the block is idle and up_state is not K, an enabled downstream port showing K takes ownership at the edge. From the next cycle, up_drive is 1, up_src is its index and dn_drive is 0. On a tie the lowest index wins. An upstream K wins over any downstream K.
- R7: While a port owns the root direction, K or SE0 on other ports and on the root port has no effect on the outputs, and up_src holds its value until the owner's end of packet (the rule in R5 applied to the owner's line).
- R8: A disabled port showing K is never selected as owner. If the owner becomes disabled, ownership is dropped at the next edge and the block returns to idle.
- R9: An up_pre pulse while the block is idle or upstream-owned has no effect on any output.
- R10: frame_count increases by one each clock and wraps from FRAME_LEN-1 to 0.
- R11: An up_sof pulse sampled at an edge sets frame_count to 0 at that edge, and counting resumes from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz full-speed bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_state | input | 2 | Decoded line state of the root port |
| up_pre | input | 1 | One-cycle pulse on the last bit of a decoded preamble token |
| up_sof | input | 1 | One-cycle pulse when a start-of-frame token is received |
| dn_state | input | 2*NPORTS | Decoded line state of each downstream port |
| dn_enabled | input | NPORTS | Port enabled flag, one per port |
| dn_lowspeed | input | NPORTS | Port attached device is low speed, one per port |
| dn_drive | output | NPORTS | Downstream driver enable, one per port |
| dn_ls_drv | output | NPORTS | Low-speed driver select, one per port |
| up_drive | output | 1 | Root port driver enable, full-speed signalling |
| up_src | output | $clog2(NPORTS) | Index of the port repeated onto the root port |
| frame_count | output | $clog2(FRAME_LEN) | Frame timer value |

## Verification
The hardest situations to reach are the edges of the low-speed window. One is a preamble arriving in the very cycle the repeat closes. Another is a port losing its enable in the middle of a packet it owns. The stimulus builds whole packet shapes (K/J runs followed by SE0 then J) and places the up_pre pulse, the enable change and competing K starts on exact cycles relative to the end of packet. A behavioural model in the bench follows the same cycle boundaries, and all outputs are compared against it on every clock.

// File: rtl/hub_repeat_gate.sv
module hub_repeat_gate #(
  parameter int NPORTS    = 4,
  parameter int FRAME_LEN = 12000,
  localparam int SW = $clog2(NPORTS),
  localparam int FW = $clog2(FRAME_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          up_state,
  input  logic                up_pre,
  input  logic                up_sof,
  input  logic [2*NPORTS-1:0] dn_state,
  input  logic [NPORTS-1:0]   dn_enabled,
  input  logic [NPORTS-1:0]   dn_lowspeed,
  output logic [NPORTS-1:0]   dn_drive,
  output logic [NPORTS-1:0]   dn_ls_drv,
  output logic                up_drive,
  output logic [SW-1:0]       up_src,
  output logic [FW-1:0]       frame_count
);

  localparam logic [1:0] ST_SE0 = 2'b00;
  localparam logic [1:0] ST_K   = 2'b10;

  typedef enum logic [1:0] {DIR_IDLE, DIR_DOWN, DIR_UP} dir_t;

  dir_t              dir;
  logic [SW-1:0]     owner;
  logic              ls_on;
  logic              eop_seen;
  logic [FW-1:0]     fcnt;
  logic [NPORTS-1:0] claim;
  logic [SW-1:0]     winner;
  logic [1:0]        src_state;
  logic              src_end;

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    assign claim[i]     = dn_enabled[i] && (dn_state[2*i +: 2] == ST_K);
    assign dn_drive[i]  = (dir == DIR_DOWN) && dn_enabled[i] && (ls_on || !dn_lowspeed[i]);
    assign dn_ls_drv[i] = (dir == DIR_DOWN) && ls_on && dn_enabled[i] && dn_lowspeed[i];
  end

  always_comb begin
    winner = '0;
    for (int i = NPORTS - 1; i >= 0; i--)
      if (claim[i]) winner = SW'(i);
  end

  assign src_state   = (dir == DIR_DOWN) ? up_state : dn_state[2*owner +: 2];
  assign src_end     = eop_seen && (src_state != ST_SE0);
  assign up_drive    = (dir == DIR_UP);
  assign up_src      = (dir == DIR_UP) ? owner : '0;
  assign frame_count = fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir      <= DIR_IDLE;
      owner    <= '0;
      ls_on    <= 1'b0;
      eop_seen <= 1'b0;
    end else begin
      case (dir)
        DIR_IDLE: begin
          eop_seen <= 1'b0;
          ls_on    <= 1'b0;
          if (up_state == ST_K) dir <= DIR_DOWN;
          else if (|claim) begin
            dir   <= DIR_UP;
            owner <= winner;
          end
        end
        DIR_DOWN: begin
          if (src_end) begin
            dir      <= DIR_IDLE;
            ls_on    <= 1'b0;
            eop_seen <= 1'b0;
          end else begin
            if (up_pre) ls_on <= 1'b1;
            if (src_state == ST_SE0) eop_seen <= 1'b1;
          end
        end
        DIR_UP: begin
          if (!dn_enabled[owner] || src_end) begin
            dir      <= DIR_IDLE;
            eop_seen <= 1'b0;
          end else if (src_state == ST_SE0) eop_seen <= 1'b1;
        end
        default: dir <= DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcnt <= '0;
    else if (up_sof || fcnt == FW'(FRAME_LEN - 1)) fcnt <= '0;
    else fcnt <= fcnt + 1'b1;
  end

  assert_ls_only_after_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> $past(up_pre));

  assert_pre_opens_ls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_DOWN && up_pre && !src_end) |=> ls_on);

  assert_owner_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_drive && $past(up_drive)) |-> $stable(up_src));

  assert_disabled_owner_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_UP && !dn_enabled[owner]) |=> !up_drive);

  assert_frame_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(up_sof) && $past(frame_count) != FW'(FRAME_LEN - 1))
      |-> frame_count == $past(frame_count) + 1'b1);

  assert_sof_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(up_sof)) |-> frame_count == '0);

endmodule

// File: tb/hub_repeat_gate_tb_top.sv
module hub_repeat_gate_tb_top;
  localparam int NP = 4;
  localparam int FL = 12000;
  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] up_state = J;
  logic up_pre = 1'b0, up_sof = 1'b0;
  logic [2*NP-1:0] dn_state = {NP{J}};
  logic [NP-1:0] dn_enabled = '1, dn_lowspeed = 4'b0100;
  logic [NP-1:0] dn_drive, dn_ls_drv;
  logic up_drive;
  logic [1:0] up_src;
  logic [13:0] frame_count;

  int checks = 0, failures = 0;
  string tag = "R1", ftag = "R10";

  always #4 clk = ~clk;

  hub_repeat_gate #(.NPORTS(NP), .FRAME_LEN(FL)) dut_i (
    .clk(clk), .rst_n(rst_n), .up_state(up_state), .up_pre(up_pre), .up_sof(up_sof),
    .dn_state(dn_state), .dn_enabled(dn_enabled), .dn_lowspeed(dn_lowspeed),
    .dn_drive(dn_drive), .dn_ls_drv(dn_ls_drv), .up_drive(up_drive),
    .up_src(up_src), .frame_count(frame_count));

  // reference model: 0 idle, 1 repeating downstream, 2 port owns root
  int m_mode = 0, m_own = 0, m_fc = 0;
  bit m_ls = 0, m_eop = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_own = 0; m_ls = 0; m_eop = 0; m_fc = 0;
    end else begin
      logic [1:0] s;
      if (m_mode == 0) begin
        m_eop = 0; m_ls = 0;
        if (up_state == K) m_mode = 1;
        else begin
          for (int i = NP - 1; i >= 0; i--)
            if (dn_enabled[i] && dn_state[2*i +: 2] == K) begin m_mode = 2; m_own = i; end
        end
      end else if (m_mode == 1) begin
        s = up_state;
        if (m_eop && s != SE0) begin m_mode = 0; m_ls = 0; m_eop = 0; end
        else begin
          if (up_pre) m_ls = 1;
          if (s == SE0) m_eop = 1;
        end
      end else begin
        s = dn_state[2*m_own +: 2];
        if (!dn_enabled[m_own] || (m_eop && s != SE0)) begin m_mode = 0; m_eop = 0; end
        else if (s == SE0) m_eop = 1;
      end
      m_fc = (up_sof || m_fc == FL - 1) ? 0 : m_fc + 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    begin
      logic [NP-1:0] e_drv, e_ls;
      for (int i = 0; i < NP; i++) begin
        e_drv[i] = (m_mode == 1) && dn_enabled[i] && (m_ls || !dn_lowspeed[i]);
        e_ls[i]  = (m_mode == 1) && m_ls && dn_enabled[i] && dn_lowspeed[i];
      end
      chk(tag, "dn_drive", int'(dn_drive), int'(e_drv));
      chk(tag, "dn_ls_drv", int'(dn_ls_drv), int'(e_ls));
      chk(tag, "up_drive", int'(up_drive), int'(m_mode == 2));
      chk(tag, "up_src", int'(up_src), (m_mode == 2) ? m_own : 0);
      chk(ftag, "frame_count", int'(frame_count), m_fc);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setp(int p, logic [1:0] v);
    dn_state[2*p +: 2] = v;
  endtask

  task automatic down_pkt(bit with_pre);
    up_state = K; tick(1);
    up_state = J; tick(1);
    up_state = K; tick(2);
    if (with_pre) begin
      up_pre = 1; tick(1); up_pre = 0;
      up_state = J; tick(3);
      up_state = K; tick(8);
      up_state = J; tick(8);
    end
    up_state = SE0; tick(2);
    up_state = J; tick(3);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R1 explicit reset-state checks
    chk("R1", "idle dn_drive", int'(dn_drive), 0);
    chk("R1", "idle up_drive", int'(up_drive), 0);

    tag = "R2"; dn_enabled = 4'b1101; down_pkt(0);
    tag = "R3"; dn_enabled = 4'b1111; down_pkt(0);
    tag = "R4"; down_pkt(1);
    dn_lowspeed = 4'b1100; down_pkt(1);
    tag = "R5"; dn_lowspeed = 4'b0100;
    up_state = K; tick(2); up_state = SE0; tick(2);
    up_state = J; up_pre = 1; tick(1); up_pre = 0; tick(3);

    tag = "R9"; up_pre = 1; tick(1); up_pre = 0; tick(2);

    tag = "R6"; setp(3, K); tick(2);
    tag = "R7"; setp(1, K); up_state = K; tick(2); setp(1, SE0); tick(1);
    setp(1, J); up_state = J; up_pre = 1; tick(1); up_pre = 0;
    setp(3, J); tick(1); setp(3, SE0); tick(2); setp(3, J); tick(3);

    tag = "R6"; setp(0, K); setp(3, K); tick(2);
    setp(0, SE0); setp(3, J); tick(1); setp(0, J); tick(3);
    up_state = K; setp(1, K); tick(2); setp(1, J);
    up_state = SE0; tick(1); up_state = J; tick(3);

    tag = "R8"; dn_enabled = 4'b1110; setp(0, K); tick(3);
    setp(0, J); setp(2, K); tick(2); dn_enabled = 4'b1010; tick(2);
    setp(2, J); dn_enabled = 4'b1111; tick(3);

    ftag = "R11"; up_sof = 1; tick(1); up_sof = 0; tick(5);
    ftag = "R10"; tick(FL + 20);
    ftag = "R11"; up_sof = 1; tick(1); up_sof = 0; tick(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule